// File: doc/BRIEF.md
# Endpoint FIFO Unit Allocator

This block hands out space in one direction's shared endpoint packet memory. The memory is split into equal units of `UNIT_BYTES` (512 by default, a power of two). A used-unit map of `NUM_UNITS` bits (128 by default, covering 64 KB) records which units are taken. An allocation request supplies an endpoint's maximum packet size and a slot count. The block rounds the packet size up to a power of two to get the segment size. It multiplies the segment size by the slot count plus one, and converts the resulting byte total to a whole number of units. It then searches the map from the lowest unit upward for the first run of free units that long. On success it marks those units used and returns their byte address. On failure it raises a fail flag.

A release request supplies a byte address and a byte size. The block clears the units they cover. Both request ports use a level request that is held until a one-cycle acknowledge. The requester drops its request in the cycle it sees the acknowledge.

The controller is a six-state machine:
- `ST_IDLE` waits for work. It takes `ST_IDLE→ST_FCLR` on a release request, or `ST_IDLE→ST_SCAN` on an allocation request.
- `ST_SCAN` examines one unit per cycle. It takes `ST_SCAN→ST_MARK` when the run is long enough, or `ST_SCAN→ST_AACK` with fail when it reaches the limit.
- `ST_MARK` sets the chosen units, then goes `ST_MARK→ST_AACK`.
- `ST_AACK` pulses the allocation acknowledge, then goes `ST_AACK→ST_IDLE`.
- `ST_FCLR` clears the released units, then goes `ST_FCLR→ST_FACK`.
- `ST_FACK` pulses the release acknowledge, then goes `ST_FACK→ST_IDLE`.

Top module: `fifo_unit_alloc`

## Requirements
- R1: After reset every unit is free and both acknowledges are low, so the first one-unit allocation returns `fifo_base`.
- R2: The segment size is `alloc_maxp` rounded up to the next power of two; a value of 0 or 1 gives 1. The unit count is ceil((alloc_slots+1) × segment / UNIT_BYTES), with a minimum of one.
- R3: An allocation takes the lowest-indexed run of contiguous free units of the required length. It returns `alloc_addr` = `fifo_base` + index × UNIT_BYTES, with `alloc_fail` low.
- R4: If no such run exists, `alloc_ack` comes with `alloc_fail` high and the map is left unchanged.
- R5: `unit_limit` is sampled when an allocation starts. The search uses only units with index below min(`unit_limit`, NUM_UNITS), so a limit of 0 always fails.
- R6: A release clears units (`free_addr`−`fifo_base`)/UNIT_BYTES onward, for ceil(`free_size`/UNIT_BYTES) units with a minimum of one. Releasing units that are already free has no other effect.
- R7: For a release sampled in `ST_IDLE`, the map is cleared at the next clock edge. `free_ack` is high during the cycle after that edge, which is the second cycle after the request was sampled.
- R8: When both requests are present in `ST_IDLE`, the release is served first.
- R9: `alloc_ack` and `free_ack` are single-cycle pulses, never high together, and `alloc_fail` is only high with `alloc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_base | input | ADDR_W | Byte address of unit 0 |
| unit_limit | input | IDX_W | Number of units the search may use |
| alloc_req | input | 1 | Allocation request, held until acknowledged |
| alloc_maxp | input | MAXP_W | Endpoint maximum packet size in bytes |
| alloc_slots | input | SLOT_W | Extra packet slots (total = slots + 1) |
| alloc_ack | output | 1 | Allocation done pulse |
| alloc_fail | output | 1 | No free run found (valid with alloc_ack) |
| alloc_addr | output | ADDR_W | Allocated byte address (valid with alloc_ack) |
| free_req | input | 1 | Release request, held until acknowledged |
| free_addr | input | ADDR_W | Byte address of the region to release |
| free_size | input | FSIZE_W | Byte size of the region to release |
| free_ack | output | 1 | Release done pulse |

## Verification
The bench builds the block with `NUM_UNITS` = 16, keeping the other parameters at their defaults. With only 16 units, a handful of requests fills the memory. This puts exhaustion, a run that fits only after an earlier release, and a limit that hides every free unit within reach in a few hundred cycles. Packet sizes range from 1 to 2047 bytes and slot counts from 0 to 3. Together these exercise power-of-two rounding across segment sizes below, at and above one unit.

// File: rtl/fifo_alloc_pkg.sv
package fifo_alloc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SCAN = 3'd1,
        ST_MARK = 3'd2,
        ST_AACK = 3'd3,
        ST_FCLR = 3'd4,
        ST_FACK = 3'd5
    } fa_state_e;

endpackage

// File: rtl/fifo_ep_bytes.sv
// Byte footprint of one endpoint: power-of-two segment times (slots + 1).
module fifo_ep_bytes #(
    parameter int MAXP_W = 11,
    parameter int SLOT_W = 2,
    localparam int SEG_W = MAXP_W + 1,
    localparam int TOT_W = SEG_W + SLOT_W + 1
) (
    input  logic [MAXP_W-1:0] maxp,
    input  logic [SLOT_W-1:0] slots,
    output logic [TOT_W-1:0]  total
);
    logic [MAXP_W-1:0] m1;
    logic [SEG_W-1:0]  seg;

    always_comb begin
        m1  = (maxp == '0) ? '0 : maxp - MAXP_W'(1);
        seg = SEG_W'(1);
        // highest set bit of (maxp-1) decides the rounded power of two
        for (int b = 0; b < MAXP_W; b++) begin
            if (m1[b]) seg = SEG_W'(1) << (b + 1);
        end
        total = TOT_W'(seg) * (TOT_W'(slots) + TOT_W'(1));
    end
endmodule

// File: rtl/fifo_bytes_to_units.sv
// Byte count to whole units, at least one, saturated to the output width.
module fifo_bytes_to_units #(
    parameter int BYTES_W = 14,
    parameter int UB_LOG  = 9,
    parameter int OUT_W   = 8,
    localparam int SUM_W  = BYTES_W + 1
) (
    input  logic [BYTES_W-1:0] bytes,
    output logic [OUT_W-1:0]   units
);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] quo;
    logic [63:0]      quo64;

    always_comb begin
        sum   = SUM_W'(bytes) + SUM_W'((1 << UB_LOG) - 1);
        quo   = sum >> UB_LOG;
        quo64 = 64'(quo);
        if (quo64 == 64'd0)
            units = OUT_W'(1);
        else if (quo64 > 64'((1 << OUT_W) - 1))
            units = '1;
        else
            units = OUT_W'(quo);
    end
endmodule

// File: rtl/fifo_unit_map.sv
// Used-unit bitmap with range set and range clear.
module fifo_unit_map #(
    parameter int NUM_UNITS = 128,
    parameter int IDX_W     = 8,
    parameter int LO_W      = 23,
    localparam int CW       = LO_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IDX_W-1:0]     set_lo,
    input  logic [IDX_W-1:0]     set_cnt,
    input  logic                 clr_en,
    input  logic [LO_W-1:0]      clr_lo,
    input  logic [IDX_W-1:0]     clr_cnt,
    output logic [NUM_UNITS-1:0] map
);
    logic [NUM_UNITS-1:0] map_q;
    logic [NUM_UNITS-1:0] set_mask;
    logic [NUM_UNITS-1:0] clr_mask;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        assign set_mask[g] = (CW'(g) >= CW'(set_lo)) &&
                             (CW'(g) <  CW'(set_lo) + CW'(set_cnt));
        assign clr_mask[g] = (CW'(g) >= CW'(clr_lo)) &&
                             (CW'(g) <  CW'(clr_lo) + CW'(clr_cnt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            map_q <= '0;
        else if (set_en)
            map_q <= map_q | set_mask;
        else if (clr_en)
            map_q <= map_q & ~clr_mask;
    end

    assign map = map_q;

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ((map_q & set_mask) == '0));

    // R6
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((map_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/fifo_alloc_ctrl.sv
// Request arbitration, first-fit serial search and acknowledge sequencing.
module fifo_alloc_ctrl
    import fifo_alloc_pkg::*;
#(
    parameter int NUM_UNITS = 128,
    parameter int IDX_W     = 8,
    parameter int LO_W      = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [IDX_W-1:0]     alloc_need,
    input  logic [IDX_W-1:0]     limit_in,
    input  logic                 free_req,
    input  logic [LO_W-1:0]      free_lo_in,
    input  logic [IDX_W-1:0]     free_cnt_in,
    input  logic [NUM_UNITS-1:0] map,
    output logic                 set_en,
    output logic [IDX_W-1:0]     set_lo,
    output logic [IDX_W-1:0]     set_cnt,
    output logic                 clr_en,
    output logic [LO_W-1:0]      clr_lo,
    output logic [IDX_W-1:0]     clr_cnt,
    output logic                 alloc_ack,
    output logic                 alloc_fail,
    output logic [IDX_W-1:0]     alloc_idx,
    output logic                 free_ack
);
    localparam logic [IDX_W-1:0] UNITS_I = IDX_W'(NUM_UNITS);

    fa_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, run_q, need_q, start_q, lim_q;
    logic [IDX_W-1:0] run_nx;
    logic [LO_W-1:0]  flo_q;
    logic [IDX_W-1:0] fcnt_q;
    logic             fail_q;
    logic             at_end;
    logic             cur_used;
    logic             run_hit;

    assign at_end   = (idx_q >= lim_q);
    assign cur_used = at_end ? 1'b1 : map[idx_q[IDX_W-2:0]];
    assign run_nx   = cur_used ? '0 : run_q + IDX_W'(1);
    assign run_hit  = !at_end && (run_nx == need_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (free_req)       state_d = ST_FCLR;
                else if (alloc_req) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (at_end)       state_d = ST_AACK;
                else if (run_hit) state_d = ST_MARK;
            end
            ST_MARK: state_d = ST_AACK;
            ST_AACK: state_d = ST_IDLE;
            ST_FCLR: state_d = ST_FACK;
            ST_FACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // search and request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            run_q   <= '0;
            need_q  <= '0;
            start_q <= '0;
            lim_q   <= '0;
            fail_q  <= 1'b0;
            flo_q   <= '0;
            fcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (free_req) begin
                        flo_q  <= free_lo_in;
                        fcnt_q <= free_cnt_in;
                    end else if (alloc_req) begin
                        need_q <= alloc_need;
                        lim_q  <= (limit_in > UNITS_I) ? UNITS_I : limit_in;
                        idx_q  <= '0;
                        run_q  <= '0;
                        fail_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (at_end) begin
                        fail_q <= 1'b1;
                    end else if (run_hit) begin
                        start_q <= idx_q + IDX_W'(1) - need_q;
                    end else begin
                        run_q <= run_nx;
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        set_en     = 1'b0;
        clr_en     = 1'b0;
        alloc_ack  = 1'b0;
        alloc_fail = 1'b0;
        free_ack   = 1'b0;
        unique case (state_q)
            ST_MARK: set_en = 1'b1;
            ST_AACK: begin
                alloc_ack  = 1'b1;
                alloc_fail = fail_q;
            end
            ST_FCLR: clr_en   = 1'b1;
            ST_FACK: free_ack = 1'b1;
            default: ;
        endcase
    end

    assign set_lo    = start_q;
    assign set_cnt   = need_q;
    assign clr_lo    = flo_q;
    assign clr_cnt   = fcnt_q;
    assign alloc_idx = start_q;

    // R5
    set_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> ({1'b0, set_lo} + {1'b0, set_cnt}) <= {1'b0, lim_q});

    // R4
    fail_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fail |-> !$past(set_en));

    // R7
    free_ack_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_ack |-> $past(clr_en));

    // R8
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && free_req && alloc_req) |=> clr_en);

    // R9
    alloc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ack |=> !alloc_ack);

    // R9
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alloc_ack, free_ack}));
endmodule

// File: rtl/fifo_unit_alloc.sv
// Top: shared endpoint FIFO unit allocator for one direction.
module fifo_unit_alloc #(
    parameter int NUM_UNITS  = 128,
    parameter int UNIT_BYTES = 512,
    parameter int ADDR_W     = 32,
    parameter int MAXP_W     = 11,
    parameter int SLOT_W     = 2,
    parameter int FSIZE_W    = $clog2(NUM_UNITS * UNIT_BYTES) + 1,
    localparam int IDX_W     = $clog2(NUM_UNITS) + 1,
    localparam int UB_LOG    = $clog2(UNIT_BYTES),
    localparam int LO_W      = ADDR_W - UB_LOG,
    localparam int TOT_W     = MAXP_W + SLOT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  fifo_base,
    input  logic [IDX_W-1:0]   unit_limit,
    input  logic               alloc_req,
    input  logic [MAXP_W-1:0]  alloc_maxp,
    input  logic [SLOT_W-1:0]  alloc_slots,
    output logic               alloc_ack,
    output logic               alloc_fail,
    output logic [ADDR_W-1:0]  alloc_addr,
    input  logic               free_req,
    input  logic [ADDR_W-1:0]  free_addr,
    input  logic [FSIZE_W-1:0] free_size,
    output logic               free_ack
);
    logic [TOT_W-1:0]     ep_total;
    logic [IDX_W-1:0]     need_units;
    logic [IDX_W-1:0]     free_units;
    logic [ADDR_W-1:0]    free_off;
    logic [LO_W-1:0]      free_lo;
    logic [NUM_UNITS-1:0] map;
    logic                 set_en, clr_en;
    logic [IDX_W-1:0]     set_lo, set_cnt, clr_cnt, alloc_idx;
    logic [LO_W-1:0]      clr_lo;

    fifo_ep_bytes #(.MAXP_W(MAXP_W), .SLOT_W(SLOT_W)) u_ep_bytes (
        .maxp  (alloc_maxp),
        .slots (alloc_slots),
        .total (ep_total)
    );

    fifo_bytes_to_units #(.BYTES_W(TOT_W), .UB_LOG(UB_LOG), .OUT_W(IDX_W)) u_need (
        .bytes (ep_total),
        .units (need_units)
    );

    fifo_bytes_to_units #(.BYTES_W(FSIZE_W), .UB_LOG(UB_LOG), .OUT_W(IDX_W)) u_rel (
        .bytes (free_size),
        .units (free_units)
    );

    assign free_off = free_addr - fifo_base;
    assign free_lo  = LO_W'(free_off >> UB_LOG);

    fifo_alloc_ctrl #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W), .LO_W(LO_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_req   (alloc_req),
        .alloc_need  (need_units),
        .limit_in    (unit_limit),
        .free_req    (free_req),
        .free_lo_in  (free_lo),
        .free_cnt_in (free_units),
        .map         (map),
        .set_en      (set_en),
        .set_lo      (set_lo),
        .set_cnt     (set_cnt),
        .clr_en      (clr_en),
        .clr_lo      (clr_lo),
        .clr_cnt     (clr_cnt),
        .alloc_ack   (alloc_ack),
        .alloc_fail  (alloc_fail),
        .alloc_idx   (alloc_idx),
        .free_ack    (free_ack)
    );

    fifo_unit_map #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W), .LO_W(LO_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_lo  (set_lo),
        .set_cnt (set_cnt),
        .clr_en  (clr_en),
        .clr_lo  (clr_lo),
        .clr_cnt (clr_cnt),
        .map     (map)
    );

    assign alloc_addr = fifo_base + (ADDR_W'(alloc_idx) << UB_LOG);

    // R9
    fail_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fail |-> alloc_ack);

    // R3
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ack && !alloc_fail) |->
            ((alloc_addr - fifo_base) < ADDR_W'(NUM_UNITS * UNIT_BYTES)));
endmodule

// File: tb/test_fifo_unit_alloc.sv
`timescale 1ns/1ps
module test_fifo_unit_alloc;
    localparam int NU   = 16;
    localparam int IW   = 5;
    localparam int FSW  = 14;
    localparam logic [31:0] BASE = 32'h0001_0000;

    typedef struct packed {
        logic [10:0] maxp;
        logic [1:0]  slots;
        logic        fail;
        logic [4:0]  idx;
    } vec_t;

    // R2/R3/R4 table: map starts empty, limit 16
    localparam vec_t VECS [7] = '{
        '{11'd512,  2'd0, 1'b0, 5'd0},   // 1 unit
        '{11'd300,  2'd1, 1'b0, 5'd1},   // seg 512 x2 -> 2 units
        '{11'd64,   2'd2, 1'b0, 5'd3},   // 192 B -> 1 unit
        '{11'd1024, 2'd2, 1'b0, 5'd4},   // 3072 B -> 6 units
        '{11'd1,    2'd0, 1'b0, 5'd10},  // 1 B -> 1 unit
        '{11'd2047, 2'd1, 1'b1, 5'd0},   // 4096 B -> 8 units, only 5 free
        '{11'd513,  2'd0, 1'b0, 5'd11}   // seg 1024 -> 2 units
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     fifo_base = BASE;
    logic [IW-1:0]   unit_limit = IW'(NU);
    logic            alloc_req = 1'b0;
    logic [10:0]     alloc_maxp = '0;
    logic [1:0]      alloc_slots = '0;
    logic            alloc_ack, alloc_fail;
    logic [31:0]     alloc_addr;
    logic            free_req = 1'b0;
    logic [31:0]     free_addr = '0;
    logic [FSW-1:0]  free_size = '0;
    logic            free_ack;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fifo_unit_alloc #(.NUM_UNITS(NU)) i_fifo_unit_alloc (
        .clk, .rst_n, .fifo_base, .unit_limit,
        .alloc_req, .alloc_maxp, .alloc_slots, .alloc_ack, .alloc_fail, .alloc_addr,
        .free_req, .free_addr, .free_size, .free_ack
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [10:0] mp, input logic [1:0] sl,
                            output logic f, output logic [31:0] a);
        int n;
        @(negedge clk);
        alloc_maxp = mp; alloc_slots = sl; alloc_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!alloc_ack && n < 400);
        if (!alloc_ack) chk(1'b0, "R9", "alloc ack timeout", 0, 1);
        f = alloc_fail; a = alloc_addr;
        alloc_req = 1'b0;
        @(negedge clk);
        chk(!alloc_ack, "R9", "alloc ack single pulse", {31'd0, alloc_ack}, 0);
    endtask

    task automatic do_free(input logic [31:0] ad, input logic [FSW-1:0] sz);
        @(negedge clk);
        free_addr = ad; free_size = sz; free_req = 1'b1;
        @(negedge clk);
        chk(!free_ack, "R7", "free ack low in clear cycle", {31'd0, free_ack}, 0);
        @(negedge clk);
        chk(free_ack, "R7", "free ack after clear", {31'd0, free_ack}, 1);
        free_req = 1'b0;
        @(negedge clk);
        chk(!free_ack, "R7", "free ack single pulse", {31'd0, free_ack}, 0);
    endtask

    task automatic expect_ok(input string req, input logic [10:0] mp, input logic [1:0] sl,
                             input int idx);
        logic f; logic [31:0] a;
        do_alloc(mp, sl, f, a);
        chk(!f, req, "alloc fail flag", {31'd0, f}, 0);
        chk(a == BASE + 32'(idx) * 512, req, "alloc address", a, BASE + 32'(idx) * 512);
    endtask

    task automatic expect_fail(input string req, input logic [10:0] mp, input logic [1:0] sl);
        logic f; logic [31:0] a;
        do_alloc(mp, sl, f, a);
        chk(f, req, "alloc fail flag", {31'd0, f}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!alloc_ack && !free_ack, "R1", "acks low after reset",
            {30'd0, alloc_ack, free_ack}, 0);

        // table walk: R2, R3, R4
        for (int v = 0; v < 7; v++) begin
            logic f; logic [31:0] a;
            do_alloc(VECS[v].maxp, VECS[v].slots, f, a);
            chk(f == VECS[v].fail, "R2/R4", "table fail flag", {31'd0, f}, {31'd0, VECS[v].fail});
            if (!VECS[v].fail)
                chk(a == BASE + 32'(VECS[v].idx) * 512, "R2/R3", "table address",
                    a, BASE + 32'(VECS[v].idx) * 512);
        end
        // used: 0..12, free: 13..15

        // R6: release units 1,2 then one-unit alloc reuses 1 (first fit, R3)
        do_free(BASE + 32'd512, FSW'(1024));
        expect_ok("R6", 11'd8, 2'd0, 1);

        // R6: zero size releases one unit (3); free now 2,3 -> 2-unit alloc at 2
        do_free(BASE + 32'd1536, FSW'(0));
        expect_ok("R6", 11'd256, 2'd3, 2);

        // R5: units 0..12 used; limit 13 hides 13..15
        unit_limit = IW'(13);
        expect_fail("R5", 11'd16, 2'd0);
        unit_limit = IW'(0);
        expect_fail("R5", 11'd16, 2'd0);
        unit_limit = IW'(NU);
        // R4: the failures marked nothing, so unit 13 is still first free
        expect_ok("R4", 11'd512, 2'd0, 13);

        // R6: releasing already-free unit 14 changes nothing; 14,15 still free
        do_free(BASE + 32'd7168, FSW'(512));
        expect_ok("R6", 11'd1024, 2'd0, 14);
        expect_fail("R4", 11'd1, 2'd0);

        // R8: simultaneous release of unit 0 and one-unit alloc
        begin
            int n;
            @(negedge clk);
            free_addr = BASE; free_size = FSW'(512); free_req = 1'b1;
            alloc_maxp = 11'd100; alloc_slots = 2'd0; alloc_req = 1'b1;
            @(negedge clk);
            chk(!alloc_ack && !free_ack, "R8", "no ack in clear cycle",
                {30'd0, alloc_ack, free_ack}, 0);
            @(negedge clk);
            chk(free_ack && !alloc_ack, "R8", "release acked first",
                {30'd0, alloc_ack, free_ack}, 1);
            free_req = 1'b0;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!alloc_ack && n < 400);
            chk(alloc_ack && !alloc_fail && alloc_addr == BASE, "R8",
                "alloc takes released unit 0", alloc_addr, BASE);
            alloc_req = 1'b0;
            @(negedge clk);
        end

        // R1: reset in the middle clears the map
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!alloc_ack && !free_ack, "R1", "acks low in reset",
            {30'd0, alloc_ack, free_ack}, 0);
        rst_n = 1'b1;
        expect_ok("R1", 11'd512, 2'd0, 0);
        expect_ok("R3", 11'd1024, 2'd3, 1); // 8 units at 1..8

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule